// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 128-bit integer execution unit for packed vector data. Each operand word is treated as sixteen 8-bit, eight 16-bit or four 32-bit lanes, picked per operation by a lane-size select. A single issue produces every lane's result at once. For example, one add in 32-bit mode returns four independent sums.

The supported operations are lane-wise wrapping add and subtract, signed minimum and maximum, and logical left and right shifts by a shared amount. There is also a per-lane leading-zero count and the four bitwise logic operations. A funnel operation joins both operands into a 256-bit value and extracts a 128-bit window from it.

The lane datapath is built as two identical 64-bit halves that each compute their own lanes. All results pass through one output register, so a result appears one clock after its request is accepted.

Top module: `simd_lane_alu`

## Requirements
- R1: `lane_sel` encodes the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, and 2'b10 or 2'b11 give 32-bit lanes. Lane k occupies bits [k*W +: W]. Opcode 4'd0 adds lane by lane modulo 2^W, and no carry passes into the next lane.
- R2: Opcode 4'd1 computes A minus B in each lane modulo 2^W, and no borrow passes between lanes.
- R3: Opcode 4'd2 returns the smaller lane value and opcode 4'd3 returns the larger one. Both compare lanes as two's-complement signed numbers.
- R4: Opcode 4'd4 shifts each lane of A left and opcode 4'd5 shifts it right. The shift is logical, the vacated bits fill with zeros, and the amount is `shamt` modulo W.
- R5: Opcodes 4'd6 (AND), 4'd7 (OR), 4'd8 (XOR) and 4'd9 (NOR) combine A and B bit by bit. Their result does not depend on `lane_sel`.
- R6: Opcode 4'd10 returns, in each lane of A, the number of leading zero bits, zero-extended to fill the lane. An all-zero lane returns W.
- R7: Opcode 4'd11 forms the 256-bit value {A, B}, with A in the upper half. It returns the 128 bits that start at bit offset `shamt` (0 to 127) of that value.
- R8: Opcodes 4'd12 to 4'd15 produce an all-zero result.
- R9: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. `result` carries that request's value in the same cycle.
- R10: When `in_valid` is low, `result` keeps its previous value.
- R11: A synchronous active-high reset clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| op_a | input | 128 | Operand A |
| op_b | input | 128 | Operand B |
| opcode | input | 4 | Operation select |
| lane_sel | input | 2 | Lane width select |
| shamt | input | 7 | Shift amount and funnel offset |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered result |

## Verification
Faults in this block are mostly mis-sliced lanes: a carry or borrow that leaks across a lane edge, a wrong sign bit in a compare, or a shift amount reduced with the wrong width. Each of these corrupts a specific lane of `result` in the cycle right after the request. Directed operands sit on lane boundaries (all-ones plus one, 0x80 against 0x7F, shifts larger than the lane, all-zero lanes). This makes each such fault visible in a single check. Random traffic across every opcode and lane width then compares every lane against a bench model. A fault in the valid pipeline or the hold logic shows up as a mismatch of `out_valid` or `result` one cycle later.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int DATA_W  = 128;
  localparam int HALF_W  = 64;
  localparam int SHAMT_W = 7;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_MIN    = 4'd2,
    OP_MAX    = 4'd3,
    OP_SLL    = 4'd4,
    OP_SRL    = 4'd5,
    OP_AND    = 4'd6,
    OP_OR     = 4'd7,
    OP_XOR    = 4'd8,
    OP_NOR    = 4'd9,
    OP_LZC    = 4'd10,
    OP_FUNNEL = 4'd11
  } simd_op_e;

  localparam logic [1:0] LANE_8  = 2'b00;
  localparam logic [1:0] LANE_16 = 2'b01;
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit #(
  parameter int W     = 8,
  parameter int SHW   = 7
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [3:0]     op,
  input  logic [SHW-1:0] sh,
  output logic [W-1:0]   y
);
  import simd_alu_pkg::*;
  localparam int SW = $clog2(W);

  logic [SW-1:0] sh_eff;
  logic [SW:0]   lz;
  logic          seen_one;

  assign sh_eff = sh[SW-1:0];

  always_comb begin
    lz = '0;
    seen_one = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (a[i]) seen_one = 1'b1;
      if (!seen_one) lz = lz + 1'b1;
    end
  end

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MIN:  y = ($signed(a) < $signed(b)) ? a : b;
      OP_MAX:  y = ($signed(a) < $signed(b)) ? b : a;
      OP_SLL:  y = a << sh_eff;
      OP_SRL:  y = a >> sh_eff;
      OP_LZC:  y = W'(lz);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_half.sv
module simd_half #(
  parameter int HW  = 64,
  parameter int SHW = 7
) (
  input  logic [HW-1:0]  a,
  input  logic [HW-1:0]  b,
  input  logic [3:0]     op,
  input  logic [1:0]     lane_sel,
  input  logic [SHW-1:0] sh,
  output logic [HW-1:0]  y
);
  import simd_alu_pkg::*;
  localparam int NW = 3;

  logic [NW-1:0][HW-1:0] y_w;

  for (genvar gi = 0; gi < NW; gi++) begin : g_width
    localparam int W = 8 << gi;
    for (genvar li = 0; li < HW / W; li++) begin : g_lane
      simd_lane_unit #(.W(W), .SHW(SHW)) lane_i (
        .a  (a[li*W +: W]),
        .b  (b[li*W +: W]),
        .op (op),
        .sh (sh),
        .y  (y_w[gi][li*W +: W])
      );
    end
  end

  always_comb begin
    case (lane_sel)
      LANE_8:  y = y_w[0];
      LANE_16: y = y_w[1];
      default: y = y_w[2];
    endcase
  end
endmodule

// File: rtl/simd_funnel.sv
module simd_funnel #(
  parameter int DW  = 128,
  parameter int SHW = 7
) (
  input  logic [DW-1:0]  hi,
  input  logic [DW-1:0]  lo,
  input  logic [SHW-1:0] sh,
  output logic [DW-1:0]  y
);
  logic [2*DW-1:0] joined;
  logic [2*DW-1:0] moved;

  assign joined = {hi, lo};
  assign moved  = joined >> sh;
  assign y      = moved[DW-1:0];
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int DW  = simd_alu_pkg::DATA_W,
  parameter int HW  = simd_alu_pkg::HALF_W,
  parameter int SHW = simd_alu_pkg::SHAMT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  input  logic [3:0]     opcode,
  input  logic [1:0]     lane_sel,
  input  logic [SHW-1:0] shamt,
  output logic           out_valid,
  output logic [DW-1:0]  result
);
  import simd_alu_pkg::*;
  localparam int NHALF = DW / HW;

  logic [DW-1:0] lane_y;
  logic [DW-1:0] funnel_y;
  logic [DW-1:0] next_y;

  for (genvar hi = 0; hi < NHALF; hi++) begin : g_half
    simd_half #(.HW(HW), .SHW(SHW)) half_i (
      .a        (op_a[hi*HW +: HW]),
      .b        (op_b[hi*HW +: HW]),
      .op       (opcode),
      .lane_sel (lane_sel),
      .sh       (shamt),
      .y        (lane_y[hi*HW +: HW])
    );
  end

  simd_funnel #(.DW(DW), .SHW(SHW)) funnel_i (
    .hi (op_a),
    .lo (op_b),
    .sh (shamt),
    .y  (funnel_y)
  );

  always_comb begin
    case (opcode)
      OP_ADD, OP_SUB, OP_MIN, OP_MAX,
      OP_SLL, OP_SRL, OP_LZC:  next_y = lane_y;
      OP_AND:    next_y = op_a & op_b;
      OP_OR:     next_y = op_a | op_b;
      OP_XOR:    next_y = op_a ^ op_b;
      OP_NOR:    next_y = ~(op_a | op_b);
      OP_FUNNEL: next_y = funnel_y;
      default:   next_y = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_y;
    end
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int DW  = 128,
  parameter int SHW = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [DW-1:0]  op_a,
  input logic [DW-1:0]  op_b,
  input logic [3:0]     opcode,
  input logic [1:0]     lane_sel,
  input logic [SHW-1:0] shamt,
  input logic           out_valid,
  input logic [DW-1:0]  result
);
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  p_add32_lane0_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 4'd0 && lane_sel == 2'b10)
    |=> result[31:0] == $past(op_a[31:0] + op_b[31:0]));

  p_xor_any_lane_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 4'd8) |=> result == $past(op_a ^ op_b));

  p_lzc8_range_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 4'd10 && lane_sel == 2'b00) |=> result[7:0] <= 8'd8);

  p_funnel_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 4'd11 && shamt == '0) |=> result == $past(op_b));

  p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode >= 4'd12) |=> result == '0);
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DW(DW), .SHW(SHW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .opcode(opcode), .lane_sel(lane_sel), .shamt(shamt),
  .out_valid(out_valid), .result(result)
);

// File: tb/simd_lane_alu_tb_top.sv
module simd_lane_alu_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic [3:0]   opcode = '0;
  logic [1:0]   lane_sel = '0;
  logic [6:0]   shamt = '0;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  simd_lane_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .lane_sel(lane_sel), .shamt(shamt),
    .out_valid(out_valid), .result(result)
  );

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7, 4'd8, 4'd9: return "R5";
      4'd10: return "R6";
      4'd11: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [127:0] ref_alu(logic [127:0] a, logic [127:0] b,
                                           logic [3:0] op, logic [1:0] ls, logic [6:0] sh);
    int w;
    logic [127:0] r;
    logic [255:0] c;
    logic [31:0] mask;
    w = (ls == 2'b00) ? 8 : (ls == 2'b01) ? 16 : 32;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    r = '0;
    case (op)
      4'd6: return a & b;
      4'd7: return a | b;
      4'd8: return a ^ b;
      4'd9: return ~(a | b);
      4'd11: begin c = {a, b}; c = c >> sh; return c[127:0]; end
      4'd12, 4'd13, 4'd14, 4'd15: return '0;
      default: ;
    endcase
    for (int l = 0; l < 128 / w; l++) begin
      logic [31:0] x, y, z;
      int xs, ys, n;
      x = 32'(a >> (l * w)) & mask;
      y = 32'(b >> (l * w)) & mask;
      xs = $signed(x << (32 - w)) >>> (32 - w);
      ys = $signed(y << (32 - w)) >>> (32 - w);
      case (op)
        4'd0: z = (x + y) & mask;
        4'd1: z = (x - y) & mask;
        4'd2: z = (xs < ys) ? x : y;
        4'd3: z = (xs < ys) ? y : x;
        4'd4: z = (x << (int'(sh) % w)) & mask;
        4'd5: z = x >> (int'(sh) % w);
        default: begin
          n = 0;
          while (n < w && x[w - 1 - n] == 1'b0) n++;
          z = 32'(n);
        end
      endcase
      r = r | (128'(z) << (l * w));
    end
    return r;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [127:0] a, logic [127:0] b, logic [3:0] op,
                        logic [1:0] ls, logic [6:0] sh);
    logic [127:0] exp;
    @(negedge clk);
    op_a = a; op_b = b; opcode = op; lane_sel = ls; shamt = sh; in_valid = 1'b1;
    exp = ref_alu(a, b, op, ls, sh);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", {127'd0, out_valid}, 128'd1);
    check(req_of(op), result, exp);
  endtask

  initial begin
    logic [127:0] a, b, held;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {127'd0, out_valid}, 128'd0);
    check("R11", result, 128'd0);
    rst = 1'b0;

    // R1: lane carry isolation and wrap
    run_op({16{8'hFF}}, {16{8'h01}}, 4'd0, 2'b00, 7'd0);
    run_op({8{16'hFFFF}}, {8{16'h0001}}, 4'd0, 2'b01, 7'd0);
    run_op({4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 4'd0, 2'b11, 7'd0);
    run_op({4{32'h0000_00FF}}, {4{32'h0000_0001}}, 4'd0, 2'b10, 7'd0);
    // R2: borrow isolation
    run_op('0, {16{8'h01}}, 4'd1, 2'b00, 7'd0);
    run_op({8{16'h0100}}, {8{16'h0001}}, 4'd1, 2'b01, 7'd0);
    // R3: signed compare on sign boundary
    run_op({16{8'h80}}, {16{8'h7F}}, 4'd2, 2'b00, 7'd0);
    run_op({16{8'h80}}, {16{8'h7F}}, 4'd3, 2'b00, 7'd0);
    run_op({4{32'h8000_0000}}, {4{32'h0000_0001}}, 4'd3, 2'b10, 7'd0);
    // R4: shift amount modulo lane width
    run_op({16{8'h81}}, '0, 4'd4, 2'b00, 7'd9);
    run_op({8{16'h8001}}, '0, 4'd5, 2'b01, 7'd17);
    run_op({4{32'h8000_0001}}, '0, 4'd4, 2'b10, 7'd31);
    // R5: logic ignores lane select
    a = {4{32'hDEAD_BEEF}}; b = {4{32'h1234_5678}};
    for (int ls = 0; ls < 4; ls++) run_op(a, b, 4'd9, 2'(ls), 7'd0);
    run_op(a, b, 4'd6, 2'b00, 7'd3);
    // R6: leading zeros incl. all-zero lanes
    run_op({8'h00, 8'h01, 8'h80, 8'h0F, {12{8'h00}}}, '0, 4'd10, 2'b00, 7'd0);
    run_op({16'h0000, 16'h0001, {6{16'h00F0}}}, '0, 4'd10, 2'b01, 7'd0);
    run_op({32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0001_0000}, '0, 4'd10, 2'b10, 7'd0);
    // R7: funnel boundaries
    a = {4{32'hA5A5_0F0F}}; b = {4{32'h3C3C_9696}};
    run_op(a, b, 4'd11, 2'b00, 7'd0);
    run_op(a, b, 4'd11, 2'b01, 7'd127);
    run_op(a, b, 4'd11, 2'b10, 7'd64);
    // R8: unused opcodes
    run_op(a, b, 4'd12, 2'b00, 7'd5);
    run_op(a, b, 4'd15, 2'b10, 7'd5);

    // R10: hold while idle, R9: out_valid drops
    held = result;
    @(negedge clk);
    op_a = ~op_a; opcode = 4'd0;
    @(negedge clk);
    check("R10", result, held);
    check("R9", {127'd0, out_valid}, 128'd0);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 3) == 0) a = a & {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 3) == 0) a = a >> $urandom_range(0, 120);
      run_op(a, b, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
             7'($urandom_range(0, 127)));
    end

    // R11: reset mid-stream
    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R11", {127'd0, out_valid}, 128'd0);
    check("R11", result, 128'd0);
    rst = 1'b0; in_valid = 1'b0;

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule